// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a small 8-bit CPU core and its external memory pins. It turns single-byte fetch and store requests into external bus cycles. The CPU raises a request with an address, a direction and a code/data flag, then holds it until the block returns a one-clock acknowledge. On a read, the byte comes back with that acknowledge.

An external cycle first puts the low address byte on a shared bidirectional port and pulses an address latch strobe, so that an outside latch can hold that byte. After that the same port carries the data byte: the block drives it for a store and releases it for a load. The upper address byte has a dedicated output port. Two further address outputs carry bits 16 and 17 only when a two-bit extension setting enables them. An active-low asynchronous wait input, synchronised inside the block, can hold the data strobe for as long as it stays low.

A strap input is captured while reset is asserted and stays fixed until the next reset. When the captured strap is 1, code fetches below a parameterised on-chip ROM size are served from the on-chip ROM in a single clock, and no external strobe moves. All other accesses go to the external bus.

Top module: `xbus_ctrl`

## Requirements
- R1: During reset and after it is released, with no request pending, `ale_o` is 0, `rd_n_o`, `wr_n_o` and `psen_n_o` are 1, `ad_oe_o` is 0 and `ack_o` is 0.
- R2: An external cycle holds `ale_o` high for exactly one clock, with the low address byte driven on `ad_o`. The next clock keeps the address driven with `ale_o` low and all strobes high. Only then does a strobe fall. With `wait_ni` high, `ack_o` is seen 5 clocks after the clock edge that accepts the request.
- R3: A load leaves `ad_oe_o` at 0 while its strobe is low. It uses `psen_n_o` when `code_i` is 1 and `rd_n_o` when `code_i` is 0. It returns on `rdata_o` the value of `ad_i` sampled on the last clock edge before the strobe rises.
- R4: A store (`we_i`=1, `code_i`=0) holds `wr_n_o` low for at least two clocks, with `ad_oe_o`=1 and `wdata_i` on `ad_o`. A request with `code_i`=1 is always a load, whatever `we_i` is.
- R5: `ahi_o` carries address bits 15:8 from the clock where `ale_o` rises until the strobe rises, and it does not change during that span.
- R6: The extension setting `cfg_ext_i`, taken when the request is accepted, is encoded as follows. 2'b00 and 2'b11 force `a16_o` and `a17_o` to 0. 2'b01 drives address bit 16 on `a16_o` and holds `a17_o` at 0. 2'b10 drives bits 16 and 17 on both outputs.
- R7: While the synchronised `wait_ni` is low, the strobe stays low and the cycle does not end. If `wait_ni` is held low from the request and released after the W-th clock edge (W of 3 or more), `ack_o` is seen W+3 clocks after acceptance.
- R8: `rom_strap_i` is captured only while reset is active. Changing it afterwards does not change where accesses go.
- R9: With a captured strap of 0, every code fetch runs an external cycle, even at address 0.
- R10: With a captured strap of 1, a code fetch whose full 18-bit address is below ROM_BYTES acknowledges one clock after acceptance. It returns `rom_rdata_i` for `rom_addr_o` = the low address bits and moves neither `ale_o` nor any strobe. Code fetches at or above ROM_BYTES, and all data accesses, go external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_ext_i | input | 2 | Extension setting for address bits 16 and 17 |
| rom_strap_i | input | 1 | On-chip code enable strap, captured in reset |
| req_i | input | 1 | CPU request, held until acknowledge |
| we_i | input | 1 | 1 = store (data space only) |
| code_i | input | 1 | 1 = code space, 0 = data space |
| addr_i | input | 18 | Request address |
| wdata_i | input | 8 | Store data |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Load data, valid with acknowledge |
| rom_addr_o | output | ROM_AW | On-chip ROM address |
| rom_rdata_i | input | 8 | On-chip ROM data (same clock) |
| ale_o | output | 1 | Address latch strobe |
| ad_o | output | 8 | Shared port, output value |
| ad_oe_o | output | 1 | Shared port output enable |
| ad_i | input | 8 | Shared port, input value |
| ahi_o | output | 8 | Address bits 15:8 |
| a16_o | output | 1 | Address bit 16 when enabled |
| a17_o | output | 1 | Address bit 17 when enabled |
| rd_n_o | output | 1 | Data-space read strobe, active low |
| wr_n_o | output | 1 | Data-space write strobe, active low |
| psen_n_o | output | 1 | Code-space read strobe, active low |
| wait_ni | input | 1 | Asynchronous wait, active low |

## Verification
The bench builds the block with ROM_BYTES = 4096. This puts the on-chip/off-chip boundary low enough that random addresses fall on both sides of it often, and it lets directed accesses at 4095 and 4096 test the edge. The 18-bit request address, together with random extension settings, shows whether bits 16 and 17 appear on the pins only when enabled. A random wait length of 3 to 8 clocks gives exact acknowledge timing behind the two-stage synchroniser.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int XB_AW = 18;
  localparam int XB_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HIT  = 3'd1,
    ST_ADDR = 3'd2,
    ST_ALEF = 3'd3,
    ST_DATA = 3'd4,
    ST_WCHK = 3'd5,
    ST_DONE = 3'd6
  } xbus_state_e;

  localparam logic [1:0] EXT_NONE  = 2'b00;
  localparam logic [1:0] EXT_A16   = 2'b01;
  localparam logic [1:0] EXT_A17   = 2'b10;
endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int ROM_BYTES = 8192
) (
  input  logic [XB_AW-1:0] addr_i,
  input  logic [1:0]       cfg_ext_i,
  input  logic             code_i,
  input  logic             strap_i,
  output logic             hit_o,
  output logic [XB_AW-1:0] ext_addr_o
);
  localparam logic [XB_AW:0] ROM_LIMIT = (XB_AW+1)'(ROM_BYTES);

  always_comb begin
    hit_o = code_i && strap_i && ({1'b0, addr_i} < ROM_LIMIT);
  end

  always_comb begin
    ext_addr_o = {2'b00, addr_i[15:0]};
    case (cfg_ext_i)
      EXT_A16: ext_addr_o = {1'b0, addr_i[16:0]};
      EXT_A17: ext_addr_o = addr_i;
      default: ext_addr_o = {2'b00, addr_i[15:0]};
    endcase
  end
endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
  import xbus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             code_i,
  input  logic             hit_i,
  input  logic [XB_AW-1:0] ext_addr_i,
  input  logic [XB_DW-1:0] wdata_i,
  input  logic             stall_i,
  input  logic [XB_DW-1:0] rom_rdata_i,
  input  logic [XB_DW-1:0] ad_i,
  output logic             ack_o,
  output logic [XB_DW-1:0] rdata_o,
  output logic             ale_o,
  output logic [XB_DW-1:0] ad_o,
  output logic             ad_oe_o,
  output logic [XB_AW-1:0] addr_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             psen_n_o
);
  xbus_state_e      state_q, state_d;
  logic [XB_AW-1:0] addr_q;
  logic [XB_DW-1:0] wdata_q, rdata_q;
  logic             store_q, code_q;
  logic             accept, load_rom, load_bus, strobe_on, addr_phase;

  assign accept   = (state_q == ST_IDLE) && req_i;
  assign load_rom = accept && hit_i;
  assign load_bus = (state_q == ST_WCHK) && !stall_i && !store_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_i) state_d = hit_i ? ST_HIT : ST_ADDR;
      ST_HIT:  state_d = ST_IDLE;
      ST_ADDR: state_d = ST_ALEF;
      ST_ALEF: state_d = ST_DATA;
      ST_DATA: state_d = ST_WCHK;
      ST_WCHK: if (!stall_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      store_q <= 1'b0;
      code_q  <= 1'b0;
    end else if (accept) begin
      addr_q  <= ext_addr_i;
      wdata_q <= wdata_i;
      store_q <= we_i && !code_i;
      code_q  <= code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (load_rom) rdata_q <= rom_rdata_i;
    else if (load_bus) rdata_q <= ad_i;
  end

  assign addr_phase = (state_q == ST_ADDR) || (state_q == ST_ALEF);
  assign strobe_on  = (state_q == ST_DATA) || (state_q == ST_WCHK);

  assign ale_o    = (state_q == ST_ADDR);
  assign ad_oe_o  = addr_phase || (strobe_on && store_q);
  assign ad_o     = addr_phase ? addr_q[XB_DW-1:0] : wdata_q;
  assign rd_n_o   = !(strobe_on && !store_q && !code_q);
  assign psen_n_o = !(strobe_on && code_q);
  assign wr_n_o   = !(strobe_on && store_q);
  assign ack_o    = (state_q == ST_HIT) || (state_q == ST_DONE);
  assign rdata_o  = rdata_q;
  assign addr_o   = addr_q;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ROM_BYTES = 8192,
  parameter int SYNC_FF   = 2,
  localparam int ROM_AW   = $clog2(ROM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_ext_i,
  input  logic              rom_strap_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              code_i,
  input  logic [XB_AW-1:0]  addr_i,
  input  logic [XB_DW-1:0]  wdata_i,
  output logic              ack_o,
  output logic [XB_DW-1:0]  rdata_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [XB_DW-1:0]  rom_rdata_i,
  output logic              ale_o,
  output logic [XB_DW-1:0]  ad_o,
  output logic              ad_oe_o,
  input  logic [XB_DW-1:0]  ad_i,
  output logic [7:0]        ahi_o,
  output logic              a16_o,
  output logic              a17_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              psen_n_o,
  input  logic              wait_ni
);
  logic             rst_n_int;
  logic             wait_n_s;
  logic             strap_q;
  logic             hit;
  logic [XB_AW-1:0] ext_addr, addr_q;

  xbus_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_n_int)
  );

  xbus_sync #(.STAGES(SYNC_FF), .RESET_VAL(1'b1)) u_wait_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .d_i   (wait_ni),
    .q_o   (wait_n_s)
  );

  // strap follows the pin only while the internal reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_n_int) strap_q <= rom_strap_i;
  end

  xbus_decode #(.ROM_BYTES(ROM_BYTES)) u_decode (
    .addr_i    (addr_i),
    .cfg_ext_i (cfg_ext_i),
    .code_i    (code_i),
    .strap_i   (strap_q),
    .hit_o     (hit),
    .ext_addr_o(ext_addr)
  );

  xbus_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .req_i      (req_i),
    .we_i       (we_i),
    .code_i     (code_i),
    .hit_i      (hit),
    .ext_addr_i (ext_addr),
    .wdata_i    (wdata_i),
    .stall_i    (!wait_n_s),
    .rom_rdata_i(rom_rdata_i),
    .ad_i       (ad_i),
    .ack_o      (ack_o),
    .rdata_o    (rdata_o),
    .ale_o      (ale_o),
    .ad_o       (ad_o),
    .ad_oe_o    (ad_oe_o),
    .addr_o     (addr_q),
    .rd_n_o     (rd_n_o),
    .wr_n_o     (wr_n_o),
    .psen_n_o   (psen_n_o)
  );

  assign rom_addr_o = addr_i[ROM_AW-1:0];
  assign ahi_o      = addr_q[15:8];
  assign a16_o      = addr_q[16];
  assign a17_o      = addr_q[17];
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] cfg_ext_i,
  input logic       ack_o,
  input logic       ale_o,
  input logic       ad_oe_o,
  input logic [7:0] ahi_o,
  input logic       a16_o,
  input logic       a17_o,
  input logic       rd_n_o,
  input logic       wr_n_o,
  input logic       psen_n_o
);
  logic any_strobe;
  assign any_strobe = !rd_n_o || !wr_n_o || !psen_n_o;

  // R2
  ale_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !any_strobe && ad_oe_o);

  // R2
  ale_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> ad_oe_o && !any_strobe);

  // R3
  read_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !psen_n_o) |-> !ad_oe_o);

  // R4
  write_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> ad_oe_o);

  // R4
  write_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_n_o) |=> !wr_n_o);

  // R5
  ahi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |-> $stable(ahi_o));

  // R6
  ext_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ale_o) && ($past(cfg_ext_i) == 2'b00 || $past(cfg_ext_i) == 2'b11))
      |-> !a16_o && !a17_o);

  // R6
  ext_a16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ale_o) && $past(cfg_ext_i) == 2'b01) |-> !a17_o);

  // R3
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !any_strobe && !ale_o);

  // R2
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!rd_n_o, !wr_n_o, !psen_n_o}) <= 1);
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_ext_i(cfg_ext_i),
  .ack_o    (ack_o),
  .ale_o    (ale_o),
  .ad_oe_o  (ad_oe_o),
  .ahi_o    (ahi_o),
  .a16_o    (a16_o),
  .a17_o    (a17_o),
  .rd_n_o   (rd_n_o),
  .wr_n_o   (wr_n_o),
  .psen_n_o (psen_n_o)
);

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_BYTES  = 4096;
  localparam int ROM_AW     = $clog2(ROM_BYTES);

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic [1:0]        cfg_ext_i;
  logic              rom_strap_i;
  logic              req_i, we_i, code_i;
  logic [17:0]       addr_i;
  logic [7:0]        wdata_i;
  logic              ack_o;
  logic [7:0]        rdata_o;
  logic [ROM_AW-1:0] rom_addr_o;
  logic [7:0]        rom_rdata_i;
  logic              ale_o;
  logic [7:0]        ad_o;
  logic              ad_oe_o;
  logic [7:0]        ad_i;
  logic [7:0]        ahi_o;
  logic              a16_o, a17_o, rd_n_o, wr_n_o, psen_n_o;
  logic              wait_ni;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xbus_ctrl #(.ROM_BYTES(ROM_BYTES)) dut (.*);

  function automatic logic [7:0] ext_model(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {a[17:16], 6'h15};
  endfunction

  function automatic logic [7:0] rom_model(input logic [ROM_AW-1:0] a);
    return a[7:0] ^ 8'hA5 ^ {4'h0, a[ROM_AW-1:ROM_AW-4]};
  endfunction

  function automatic logic [17:0] mask_ext(input logic [17:0] a, input logic [1:0] m);
    if (m == 2'b01) return {1'b0, a[16:0]};
    if (m == 2'b10) return a;
    return {2'b00, a[15:0]};
  endfunction

  // bus-side memory model and monitor
  logic [17:0] lat;
  int          ale_cnt, rd_cnt, wr_cnt, ps_cnt;
  logic        ahi_bad, ad_oe_bad;
  logic [7:0]  wr_seen;

  assign rom_rdata_i = rom_model(rom_addr_o);
  assign ad_i = (!rd_n_o || !psen_n_o) ? ext_model(lat) : 8'h00;

  always @(negedge clk_i) begin
    if (ale_o) begin
      ale_cnt <= ale_cnt + 1;
      lat <= {a17_o, a16_o, ahi_o, ad_o};
      if (!ad_oe_o) ad_oe_bad <= 1'b1;
    end
    if (!rd_n_o) rd_cnt <= rd_cnt + 1;
    if (!psen_n_o) ps_cnt <= ps_cnt + 1;
    if (!wr_n_o) begin
      wr_cnt <= wr_cnt + 1;
      wr_seen <= ad_o;
      if (!ad_oe_o) ad_oe_bad <= 1'b1;
    end
    if ((!rd_n_o || !wr_n_o || !psen_n_o) && ahi_o != lat[15:8]) ahi_bad <= 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_ni = 1'b0;
    rom_strap_i = strap;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic xfer(input logic we, input logic code, input logic [17:0] a,
                      input logic [7:0] wd, input logic [1:0] m, input int w,
                      input logic strap);
    int n;
    bit got;
    bit hit;
    bit store;
    logic [17:0] ea;
    int exp_lat;
    hit   = code && strap && (a < ROM_BYTES);
    store = we && !code;
    ea    = mask_ext(a, m);
    if (hit) w = 0;
    exp_lat = hit ? 1 : ((w == 0) ? 5 : w + 3);
    @(negedge clk_i);
    ale_cnt = 0; rd_cnt = 0; wr_cnt = 0; ps_cnt = 0;
    ahi_bad = 1'b0; ad_oe_bad = 1'b0;
    req_i = 1'b1; we_i = we; code_i = code; addr_i = a; wdata_i = wd;
    cfg_ext_i = m;
    if (w > 0) wait_ni = 1'b0;
    n = 0; got = 0;
    while (!got && n < 60) begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      if (w > 0 && n == w) wait_ni = 1'b1;
      if (ack_o) got = 1;
    end
    req_i = 1'b0;
    wait_ni = 1'b1;
    // R2 R7 R10 acknowledge timing
    chk(got && n == exp_lat, hit ? "R10 latency" : (w > 0 ? "R7 wait latency" : "R2 latency"),
        n, exp_lat);
    if (hit) begin
      // R10 no bus activity, ROM data returned
      chk(ale_cnt == 0 && rd_cnt == 0 && ps_cnt == 0 && wr_cnt == 0, "R10 bus quiet",
          ale_cnt + rd_cnt + ps_cnt + wr_cnt, 0);
      chk(rdata_o == rom_model(a[ROM_AW-1:0]), "R10 rom data", rdata_o,
          rom_model(a[ROM_AW-1:0]));
    end else begin
      chk(ale_cnt == 1 && !ad_oe_bad, "R2 ale pulse", ale_cnt, 1);
      // R5 R6 address on pins
      chk(lat == ea, "R6 ext address", lat, ea);
      chk(!ahi_bad, "R5 upper byte held", ahi_bad, 0);
      if (store) begin
        chk(wr_cnt >= 2 && rd_cnt == 0 && ps_cnt == 0, "R4 write strobe", wr_cnt, 2);
        chk(wr_seen == wd, "R4 write data", wr_seen, wd);
      end else begin
        if (code) chk(ps_cnt >= 2 && rd_cnt == 0 && wr_cnt == 0, "R3 code strobe", ps_cnt, 2);
        else      chk(rd_cnt >= 2 && ps_cnt == 0 && wr_cnt == 0, "R3 data strobe", rd_cnt, 2);
        chk(rdata_o == ext_model(ea), "R3 read data", rdata_o, ext_model(ea));
      end
    end
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    req_i = 0; we_i = 0; code_i = 0; addr_i = '0; wdata_i = '0;
    cfg_ext_i = 2'b00; wait_ni = 1'b1;
    rst_ni = 1'b0; rom_strap_i = 1'b1;
    repeat (2) @(negedge clk_i);
    // R1 during reset
    chk(!ale_o && rd_n_o && wr_n_o && psen_n_o && !ad_oe_o && !ack_o, "R1 in reset",
        {ale_o, rd_n_o, wr_n_o, psen_n_o, ad_oe_o, ack_o}, 6'b011100);
    do_reset(1'b1);
    // R1 after release
    chk(!ale_o && rd_n_o && wr_n_o && psen_n_o && !ad_oe_o && !ack_o, "R1 after reset",
        {ale_o, rd_n_o, wr_n_o, psen_n_o, ad_oe_o, ack_o}, 6'b011100);

    // R10 boundary
    xfer(0, 1, 18'd0,    8'h00, 2'b00, 0, 1'b1);
    xfer(0, 1, 18'd4095, 8'h00, 2'b00, 0, 1'b1);
    xfer(0, 1, 18'd4096, 8'h00, 2'b00, 0, 1'b1);
    xfer(0, 0, 18'd10,   8'h00, 2'b00, 0, 1'b1);
    xfer(0, 1, 18'h10010, 8'h00, 2'b00, 0, 1'b1);
    // R4 store and code-with-we
    xfer(1, 0, 18'h2A5C3, 8'h9E, 2'b10, 0, 1'b1);
    xfer(1, 1, 18'h05123, 8'h77, 2'b00, 0, 1'b1);
    // R6 modes
    xfer(0, 0, 18'h3FFFF, 8'h00, 2'b00, 0, 1'b1);
    xfer(0, 0, 18'h3FFFF, 8'h00, 2'b01, 0, 1'b1);
    xfer(0, 0, 18'h3FFFF, 8'h00, 2'b10, 0, 1'b1);
    xfer(0, 0, 18'h3FFFF, 8'h00, 2'b11, 0, 1'b1);
    // R7 waits
    xfer(0, 0, 18'h01234, 8'h00, 2'b00, 3, 1'b1);
    xfer(1, 0, 18'h04321, 8'h5A, 2'b01, 10, 1'b1);
    // R8 strap changed after reset has no effect
    rom_strap_i = 1'b0;
    xfer(0, 1, 18'd5, 8'h00, 2'b00, 0, 1'b1);
    // R9 strap captured low
    do_reset(1'b0);
    rom_strap_i = 1'b1;
    xfer(0, 1, 18'd5, 8'h00, 2'b00, 0, 1'b0);
    xfer(0, 1, 18'd0, 8'h00, 2'b00, 4, 1'b0);

    do_reset(1'b1);
    for (int i = 0; i < 150; i++) begin
      logic [17:0] a;
      int w;
      a = 18'($urandom);
      if ($urandom_range(1, 0) == 1) a = {5'b0, a[12:0]};
      w = ($urandom_range(1, 0) == 1) ? 0 : int'($urandom_range(8, 3));
      xfer(1'($urandom), 1'($urandom), a, 8'($urandom), 2'($urandom), w, 1'b1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule